// File: doc/BRIEF.md
# Receive Stream Command Queue

This block gathers receive-streaming commands that software writes as three separate 32-bit register writes and hands each finished command to a downstream consumer through a small first-in first-out queue. The first write sets the mode flags and the sample count. The second write sets the start second. The third write sets the start tick. Only that third write commits the whole 96-bit command, so a consumer never sees a half-written command.

The consumer takes commands through a valid/ready handshake. The head of the queue stays on the output until it is taken. The block reports when the queue is full. If a command arrives while the queue is full and no slot frees in that cycle, the command is dropped and a sticky overflow flag is set. A write to a separate clear address empties the queue and clears the overflow flag.

Queue occupancy is tracked by a three-state machine:
- `Q_EMPTY`: no entries are held.
- `Q_PARTIAL`: at least one entry is held and at least one slot is free.
- `Q_FULL`: all `DEPTH` slots are held.

Its transitions are:
- `first_push`: `Q_EMPTY` to `Q_PARTIAL`, or to `Q_FULL` when `DEPTH` is 1.
- `fill`: `Q_PARTIAL` to `Q_FULL`, when a push takes the last free slot.
- `drain`: `Q_PARTIAL` to `Q_EMPTY`, when a pop takes the last entry.
- `release`: `Q_FULL` to `Q_PARTIAL`, when a pop happens without a push.
- `flush`: any state to `Q_EMPTY`, on a clear write.

A push and a pop in the same cycle leave the state unchanged.

Top module: `rx_cmd_queue`

## Requirements
- R1: While and after reset, with no writes, `cmd_valid`, `q_full` and `q_overflow` are all 0.
- R2: Register address 0 takes the mode word. Bit 31 is the start-now flag, bit 30 is the chain flag, and bits 29:0 are the sample count. Address 1 takes the start second. Address 2 takes the start tick. Address 3 is the clear address.
- R3: Writes to address 0 or 1 only update staging registers. They never add an entry to the queue.
- R4: A write to address 2 commits the staged word, the staged second and the written tick as one entry, visible from the next cycle. The staged values are kept, so a later tick-only write commits them again.
- R5: Entries leave in the order they were committed. A pop happens in a cycle where both `cmd_valid` and `cmd_ready` are 1. While the head is not popped, it stays unchanged.
- R6: After `DEPTH` commits with no pops, `q_full` is 1.
- R7: A commit while the queue is full and no pop happens is dropped. It sets `q_overflow`, which stays at 1 and leaves the held entries unchanged.
- R8: A commit in the same cycle as a pop from a full queue is accepted. The queue stays full and `q_overflow` stays 0.
- R9: A commit and a pop in the same cycle on a partly filled queue leave the number of entries unchanged.
- R10: A write to address 3 empties the queue and clears `q_overflow` by the next cycle. It leaves the staged word and second intact.
- R11: `cmd_ready` while the queue is empty has no effect on later entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 word, 1 seconds, 2 ticks/commit, 3 clear) |
| wr_data | input | 32 | Register write data |
| cmd_ready | input | 1 | Consumer accepts head entry |
| cmd_valid | output | 1 | Head entry present |
| cmd_now | output | 1 | Head start-now flag |
| cmd_chain | output | 1 | Head chain flag |
| cmd_count | output | 30 | Head sample count |
| cmd_secs | output | 32 | Head start second |
| cmd_ticks | output | 32 | Head start tick |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_overflow | output | 1 | Sticky: a commit was dropped |

## Verification
A commit and a pop can fall in the same cycle. The case that matters most is a full queue, where whether the commit survives depends on the pop in that very cycle. The bench drives the tick write and `cmd_ready` on the same clock edge, once with the queue full and once with it partly filled. It then drains the queue and compares the whole popped order against the expected sequence, and checks that `q_full` and `q_overflow` match a slot freed and refilled in one cycle.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
    localparam int WORD_W  = 32;
    localparam int COUNT_W = 30;

    typedef enum logic [1:0] {
        RA_WORD  = 2'd0,
        RA_SECS  = 2'd1,
        RA_TICKS = 2'd2,
        RA_CLEAR = 2'd3
    } rsq_addr_e;

    typedef struct packed {
        logic               now;
        logic               chain;
        logic [COUNT_W-1:0] count;
        logic [WORD_W-1:0]  secs;
        logic [WORD_W-1:0]  ticks;
    } rsq_cmd_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } rsq_state_e;
endpackage

// File: rtl/rsq_stage.sv
`timescale 1ns/1ps
module rsq_stage
    import rsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              commit,
    output logic              clear_req,
    output rsq_cmd_t          new_cmd
);
    rsq_addr_e         addr;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] secs_q;

    assign addr = rsq_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            secs_q <= '0;
        end else if (wr_en) begin
            if (addr == RA_WORD) word_q <= wr_data;
            if (addr == RA_SECS) secs_q <= wr_data;
        end
    end

    always_comb begin
        commit        = wr_en && (addr == RA_TICKS);
        clear_req     = wr_en && (addr == RA_CLEAR);
        new_cmd.now   = word_q[WORD_W-1];
        new_cmd.chain = word_q[WORD_W-2];
        new_cmd.count = word_q[COUNT_W-1:0];
        new_cmd.secs  = secs_q;
        new_cmd.ticks = wr_data;
    end
endmodule

// File: rtl/rsq_store.sv
`timescale 1ns/1ps
module rsq_store
    import rsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] wr_ptr,
    input  rsq_cmd_t         wr_cmd,
    input  logic [PTR_W-1:0] rd_ptr,
    output rsq_cmd_t         rd_cmd
);
    rsq_cmd_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_ptr] <= wr_cmd;
    end

    assign rd_cmd = mem[rd_ptr];
endmodule

// File: rtl/rsq_ctrl.sv
`timescale 1ns/1ps
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             clear_req,
    input  logic             pop_ready,
    output logic             we,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             head_valid,
    output logic             full,
    output logic             overflow
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

    rsq_state_e       state_q, state_d;
    logic [LVL_W-1:0] level_q, level_d;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic             ovf_q;
    logic             pop, accept, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_TOP) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop     = (state_q != Q_EMPTY) && pop_ready && !clear_req;
        accept  = commit && ((state_q != Q_FULL) || pop);
        drop    = commit && !accept;
        level_d = level_q + LVL_W'(accept) - LVL_W'(pop);
        state_d = state_q;
        if (clear_req) begin
            state_d = Q_EMPTY;
        end else begin
            unique case (state_q)
                Q_EMPTY:   if (accept)
                               state_d = (level_d == LVL_MAX) ? Q_FULL : Q_PARTIAL;
                Q_PARTIAL: if (level_d == '0)
                               state_d = Q_EMPTY;
                           else if (level_d == LVL_MAX)
                               state_d = Q_FULL;
                Q_FULL:    if (level_d != LVL_MAX)
                               state_d = (level_d == '0) ? Q_EMPTY : Q_PARTIAL;
                default:   state_d = Q_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_req) begin
            state_q  <= Q_EMPTY;
            level_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            if (accept) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)    rd_ptr_q <= bump(rd_ptr_q);
            if (drop)   ovf_q    <= 1'b1;
        end
    end

    always_comb begin
        we         = accept;
        wr_ptr     = wr_ptr_q;
        rd_ptr     = rd_ptr_q;
        head_valid = (state_q != Q_EMPTY);
        full       = (state_q == Q_FULL);
        overflow   = ovf_q;
    end
endmodule

// File: rtl/rx_cmd_queue.sv
`timescale 1ns/1ps
module rx_cmd_queue
    import rsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        cmd_ready,
    output logic        cmd_valid,
    output logic        cmd_now,
    output logic        cmd_chain,
    output logic [29:0] cmd_count,
    output logic [31:0] cmd_secs,
    output logic [31:0] cmd_ticks,
    output logic        q_full,
    output logic        q_overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             commit, clear_req, we;
    rsq_cmd_t         new_cmd, head_cmd;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    rsq_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit   (commit),
        .clear_req(clear_req),
        .new_cmd  (new_cmd)
    );

    rsq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .clear_req (clear_req),
        .pop_ready (cmd_ready),
        .we        (we),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .head_valid(cmd_valid),
        .full      (q_full),
        .overflow  (q_overflow)
    );

    rsq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .we    (we),
        .wr_ptr(wr_ptr),
        .wr_cmd(new_cmd),
        .rd_ptr(rd_ptr),
        .rd_cmd(head_cmd)
    );

    assign cmd_now   = head_cmd.now;
    assign cmd_chain = head_cmd.chain;
    assign cmd_count = head_cmd.count;
    assign cmd_secs  = head_cmd.secs;
    assign cmd_ticks = head_cmd.ticks;
endmodule

// File: rtl/rx_cmd_queue_chk.sv
`timescale 1ns/1ps
module rx_cmd_queue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        cmd_ready,
    input logic        cmd_valid,
    input logic        cmd_now,
    input logic        cmd_chain,
    input logic [29:0] cmd_count,
    input logic [31:0] cmd_secs,
    input logic [31:0] cmd_ticks,
    input logic        q_full,
    input logic        q_overflow
);
    logic popping, commit_w, clear_w, stage_w;
    assign popping  = cmd_valid && cmd_ready;
    assign commit_w = wr_en && (wr_addr == 2'd2);
    assign clear_w  = wr_en && (wr_addr == 2'd3);
    assign stage_w  = wr_en && (wr_addr[1] == 1'b0);

    // R3
    stage_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_w && !popping) |=> ($stable(cmd_valid) && $stable(q_full)));

    // R4
    commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_w && !cmd_valid) |=> (cmd_valid && cmd_ticks == $past(wr_data)));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !clear_w) |=>
        (cmd_valid && $stable(cmd_now) && $stable(cmd_chain) && $stable(cmd_count)
         && $stable(cmd_secs) && $stable(cmd_ticks)));

    // R6
    full_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> cmd_valid);

    // R7
    drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_w && q_full && !cmd_ready) |=> (q_overflow && q_full));

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_overflow && !clear_w) |=> q_overflow);

    // R8
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_w && q_full && cmd_ready && !q_overflow) |=> (q_full && !q_overflow));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_w |=> (!cmd_valid && !q_overflow && !q_full));
endmodule

bind rx_cmd_queue rx_cmd_queue_chk u_chk (.*);

// File: tb/rx_cmd_queue_bench.sv
`timescale 1ns/1ps
module rx_cmd_queue_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid, cmd_now, cmd_chain, q_full, q_overflow;
    logic [29:0] cmd_count;
    logic [31:0] cmd_secs, cmd_ticks;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rx_cmd_queue #(.DEPTH(DEPTH)) u_rx_cmd_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
        .cmd_now(cmd_now), .cmd_chain(cmd_chain), .cmd_count(cmd_count),
        .cmd_secs(cmd_secs), .cmd_ticks(cmd_ticks), .q_full(q_full),
        .q_overflow(q_overflow)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] mk(input logic now, input logic chain,
                                       input logic [29:0] cnt, input logic [31:0] s,
                                       input logic [31:0] t);
        return {now, chain, cnt, s, t};
    endfunction

    function automatic logic [95:0] head();
        return {cmd_now, cmd_chain, cmd_count, cmd_secs, cmd_ticks};
    endfunction

    function automatic logic [95:0] ent(input int i);
        return mk(i[0], i[1], 30'h100 + 30'(i), 32'd1000 + 32'(i), 32'd2000 + 32'(i));
    endfunction

    // one register write, optionally with a pop in the same cycle
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic pop);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cmd_ready = pop;
        @(negedge clk);
        wr_en = 1'b0; cmd_ready = 1'b0;
    endtask

    task automatic stage(input logic [95:0] c);
        wr(2'd0, c[95:64], 1'b0);
        wr(2'd1, c[63:32], 1'b0);
    endtask

    task automatic push(input logic [95:0] c);
        stage(c);
        wr(2'd2, c[31:0], 1'b0);
    endtask

    task automatic pop_exp(input string req, input logic [95:0] e);
        chk({req, " head valid"}, 96'(cmd_valid), 96'd1);
        chk({req, " head data"}, head(), e);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid", 96'(cmd_valid), 96'd0);
        chk("R1 full", 96'(q_full), 96'd0);
        chk("R1 overflow", 96'(q_overflow), 96'd0);
    endtask

    task automatic t_stage_only();
        wr(2'd3, 32'd0, 1'b0);
        wr(2'd0, 32'hC000_0005, 1'b0);
        chk("R3 after word", 96'(cmd_valid), 96'd0);
        wr(2'd1, 32'd77, 1'b0);
        chk("R3 after secs", 96'(cmd_valid), 96'd0);
    endtask

    task automatic t_single();
        logic [95:0] c;
        c = mk(1'b1, 1'b0, 30'h123_4567, 32'd5, 32'd9);
        wr(2'd3, 32'd0, 1'b0);
        push(c);
        chk("R2 now bit31", 96'(cmd_now), 96'd1);
        chk("R2 chain bit30", 96'(cmd_chain), 96'd0);
        chk("R2 count", 96'(cmd_count), 96'h123_4567);
        chk("R4 full entry", head(), c);
        wr(2'd2, 32'hA, 1'b0);
        pop_exp("R5 first", c);
        pop_exp("R4 restaged", mk(1'b1, 1'b0, 30'h123_4567, 32'd5, 32'hA));
        chk("R5 empty after", 96'(cmd_valid), 96'd0);
    endtask

    task automatic t_full_overflow();
        wr(2'd3, 32'd0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R6 not full early", 96'(q_full), 96'd0);
            push(ent(i));
        end
        chk("R6 full", 96'(q_full), 96'd1);
        repeat (3) @(negedge clk);
        chk("R5 head held", head(), ent(0));
        push(ent(50));
        chk("R7 overflow", 96'(q_overflow), 96'd1);
        chk("R7 still full", 96'(q_full), 96'd1);
        for (int i = 0; i < DEPTH; i++) pop_exp("R7 order kept", ent(i));
        chk("R7 dropped absent", 96'(cmd_valid), 96'd0);
        chk("R7 sticky", 96'(q_overflow), 96'd1);
        wr(2'd3, 32'd0, 1'b0);
        chk("R10 overflow cleared", 96'(q_overflow), 96'd0);
    endtask

    task automatic t_full_pushpop();
        wr(2'd3, 32'd0, 1'b0);
        for (int i = 0; i < DEPTH; i++) push(ent(i));
        stage(ent(60));
        wr(2'd2, ent(60)[31:0], 1'b1);
        chk("R8 full kept", 96'(q_full), 96'd1);
        chk("R8 no overflow", 96'(q_overflow), 96'd0);
        for (int i = 1; i < DEPTH; i++) pop_exp("R8 order", ent(i));
        pop_exp("R8 accepted tail", ent(60));
        chk("R8 empty", 96'(cmd_valid), 96'd0);
    endtask

    task automatic t_partial_pushpop();
        wr(2'd3, 32'd0, 1'b0);
        push(ent(10));
        push(ent(11));
        stage(ent(12));
        wr(2'd2, ent(12)[31:0], 1'b1);
        chk("R9 not full", 96'(q_full), 96'd0);
        pop_exp("R9 second", ent(11));
        pop_exp("R9 third", ent(12));
        chk("R9 count unchanged", 96'(cmd_valid), 96'd0);
    endtask

    task automatic t_clear();
        wr(2'd3, 32'd0, 1'b0);
        push(ent(20));
        push(ent(21));
        push(ent(22));
        wr(2'd3, 32'd0, 1'b0);
        chk("R10 emptied", 96'(cmd_valid), 96'd0);
        wr(2'd2, 32'd7, 1'b0);
        pop_exp("R10 staging kept", mk(ent(22)[95], ent(22)[94], ent(22)[93:64],
                                       ent(22)[63:32], 32'd7));
    endtask

    task automatic t_empty_pop();
        wr(2'd3, 32'd0, 1'b0);
        @(negedge clk);
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        cmd_ready = 1'b0;
        chk("R11 still empty", 96'(cmd_valid), 96'd0);
        push(ent(30));
        push(ent(31));
        pop_exp("R11 first intact", ent(30));
        pop_exp("R11 second intact", ent(31));
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage_only();
        t_single();
        t_full_overflow();
        t_full_pushpop();
        t_partial_pushpop();
        t_clear();
        t_empty_pop();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule